// File: doc/BRIEF.md
# Queue-Class Mapper with Weighted Deficit Round Robin

This block accepts packet descriptors, turns each one into a 9-bit queue ID, and stores it in a small per-queue descriptor FIFO. The 512-entry ID space has fixed ranges. Virtual output queues toward the switch use 504..511. Datagram link queues use 440..503, and unassigned link traffic is spread over them by a flow hash. Reserved-flow queues use 256..439. The processor path uses 0..255, where traffic returning from the processor is shifted into the upper half of a q / q+128 pair.

The ID ranges stay intact while fewer physical queues are built. A queue ID lands in slot `qid mod NQ`. Each slot keeps a running byte count, a byte discard threshold and a round-robin quota, and both the threshold and the quota can be written at run time. A packet that would overflow its slot is discarded and reported with a one-cycle pulse. Departures leave through a valid/ready port, and a weighted deficit round-robin scheduler picks the slot. The byte count of any slot can be read at any time.

Top module: `qcw_top`

## Requirements
- R1: A descriptor of kind 2 (switch-bound) gets queue ID 504 plus its 3-bit output port.
- R2: A descriptor of kind 0 (link, no assigned queue) gets queue ID 440 plus its 6-bit hash.
- R3: A descriptor of kind 1 keeps its given queue ID. A descriptor of kind 3 (returning from the processor) gets 128 plus the low 7 bits of its given ID.
- R4: A descriptor is stored in slot `qid mod NQ`. `qry_bytes_o` shows the byte count of the slot selected by `qry_slot_i`, combinationally.
- R5: A descriptor is discarded when the slot's byte count plus its length would exceed the slot threshold. `drop_o` is high in the cycle after the offer, and the slot's count and contents do not change.
- R6: A descriptor offered to a slot that already holds DEPTH descriptors is discarded in the same way.
- R7: A slot's byte count equals the bytes accepted into it minus the bytes that have left it.
- R8: The scheduler visits slots in ascending order and wraps around. On each visit to a non-empty slot it adds the slot quota to the slot's deficit. It then sends head packets while the head length does not exceed the deficit, and subtracts each length sent.
- R9: A slot whose head exceeds its deficit keeps the deficit for its next visit. A slot found empty has its deficit cleared.
- R10: Whenever all slots are empty, the scheduler returns to slot 0 and clears every deficit.
- R11: While `deq_valid_o` is high and `deq_ready_i` is low, the offered packet stays the same and the scheduler does not advance.
- R12: During and right after reset, `deq_valid_o` and `drop_o` are low, every byte count is zero, thresholds are all ones, and quotas equal QUOTA_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Descriptor offered this cycle |
| enq_kind_i | input | 2 | 0 hashed link, 1 explicit ID, 2 switch-bound, 3 processor return |
| enq_qid_i | input | 9 | Given queue ID (kinds 1 and 3) |
| enq_port_i | input | 3 | Switch output port (kind 2) |
| enq_hash_i | input | 6 | Flow hash (kind 0) |
| enq_len_i | input | LW | Packet length in bytes |
| drop_o | output | 1 | Pulse: previous offer discarded |
| cfg_we_i | input | 1 | Write threshold and quota of cfg_slot_i |
| cfg_slot_i | input | log2(NQ) | Slot to configure |
| cfg_thresh_i | input | BW | Byte discard threshold |
| cfg_quota_i | input | LW | Round-robin quota in bytes |
| qry_slot_i | input | log2(NQ) | Slot whose byte count is shown |
| qry_bytes_o | output | BW | Byte count of the queried slot |
| deq_valid_o | output | 1 | Packet offered for departure |
| deq_ready_i | input | 1 | Link accepts the offered packet |
| deq_qid_o | output | 9 | Queue ID of the offered packet |
| deq_len_o | output | LW | Length of the offered packet |

## Verification
A byte count that drifts shows up on `qry_bytes_o` at the very next query. It also shows up as a wrong `drop_o` decision on the next offer that comes near the threshold. A deficit that is not carried over or not cleared changes the order of departures within one round of the scheduler, so the scoreboard catches it at the first misplaced packet. A wrong queue-ID mapping shows up at the departure port as a wrong ID or a wrong slot order. A bad rewind after idle shows up in the first packet of the next burst.

// File: rtl/qcw_pkg.sv
package qcw_pkg;
  localparam int QID_W = 9;
  localparam logic [QID_W-1:0] VOQ_BASE    = 9'd504;
  localparam logic [QID_W-1:0] DGRAM_BASE  = 9'd440;
  localparam logic [QID_W-1:0] RETURN_BASE = 9'd128;

  typedef enum logic [1:0] {
    KIND_HASH   = 2'd0,
    KIND_QID    = 2'd1,
    KIND_SWITCH = 2'd2,
    KIND_RETURN = 2'd3
  } kind_e;
endpackage

// File: rtl/qcw_qid_map.sv
module qcw_qid_map
  import qcw_pkg::*;
(
  input  logic [1:0]       kind_i,
  input  logic [QID_W-1:0] qid_i,
  input  logic [2:0]       port_i,
  input  logic [5:0]       hash_i,
  output logic [QID_W-1:0] qid_o
);
  always_comb begin
    unique case (kind_e'(kind_i))
      KIND_HASH:   qid_o = DGRAM_BASE + QID_W'(hash_i);
      KIND_QID:    qid_o = qid_i;
      KIND_SWITCH: qid_o = VOQ_BASE + QID_W'(port_i);
      default:     qid_o = RETURN_BASE | QID_W'(qid_i[6:0]);
    endcase
  end
endmodule

// File: rtl/qcw_desc_fifo.sv
module qcw_desc_fifo #(
  parameter  int EW    = 21,
  parameter  int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [EW-1:0] din_i,
  output logic [EW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [EW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  // R6
  depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R8
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/qcw_wdrr.sv
module qcw_wdrr #(
  parameter  int NQ  = 8,
  parameter  int LW  = 12,
  localparam int SW  = $clog2(NQ),
  localparam int DFW = LW + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NQ-1:0]          empty_i,
  input  logic [NQ-1:0][LW-1:0]  head_len_i,
  input  logic [NQ-1:0][LW-1:0]  quota_i,
  input  logic                   ready_i,
  output logic                   valid_o,
  output logic                   pop_o,
  output logic [SW-1:0]          sel_o
);
  logic           serve_q;
  logic [SW-1:0]  cur_q;
  logic [DFW-1:0] def_q [NQ];
  logic [DFW-1:0] head;
  logic           fits, idle;
  logic [SW-1:0]  cur_nxt;

  assign head    = {1'b0, head_len_i[cur_q]};
  assign fits    = head <= def_q[cur_q];
  assign idle    = &empty_i;
  assign cur_nxt = (cur_q == SW'(NQ - 1)) ? '0 : cur_q + SW'(1);
  assign valid_o = serve_q && !empty_i[cur_q] && fits;
  assign pop_o   = valid_o && ready_i;
  assign sel_o   = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serve_q <= 1'b0;
      cur_q   <= '0;
      for (int i = 0; i < NQ; i++) def_q[i] <= '0;
    end else if (idle) begin
      serve_q <= 1'b0;
      cur_q   <= '0;
      for (int i = 0; i < NQ; i++) def_q[i] <= '0;
    end else if (ready_i) begin
      if (!serve_q) begin
        if (empty_i[cur_q]) begin
          def_q[cur_q] <= '0;
          cur_q        <= cur_nxt;
        end else begin
          def_q[cur_q] <= def_q[cur_q] + DFW'(quota_i[cur_q]);
          serve_q      <= 1'b1;
        end
      end else if (empty_i[cur_q]) begin
        def_q[cur_q] <= '0;
        cur_q        <= cur_nxt;
        serve_q      <= 1'b0;
      end else if (fits) begin
        def_q[cur_q] <= def_q[cur_q] - head;
      end else begin
        cur_q   <= cur_nxt;
        serve_q <= 1'b0;
      end
    end
  end

  // R10
  rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> (sel_o == '0) && !valid_o);
endmodule

// File: rtl/qcw_top.sv
module qcw_top
  import qcw_pkg::*;
#(
  parameter  int NQ        = 8,
  parameter  int DEPTH     = 4,
  parameter  int LW        = 12,
  parameter  int QUOTA_RST = 1500,
  localparam int SW        = $clog2(NQ),
  localparam int BW        = LW + $clog2(DEPTH + 1),
  localparam int EW        = QID_W + LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_valid_i,
  input  logic [1:0]       enq_kind_i,
  input  logic [QID_W-1:0] enq_qid_i,
  input  logic [2:0]       enq_port_i,
  input  logic [5:0]       enq_hash_i,
  input  logic [LW-1:0]    enq_len_i,
  output logic             drop_o,
  input  logic             cfg_we_i,
  input  logic [SW-1:0]    cfg_slot_i,
  input  logic [BW-1:0]    cfg_thresh_i,
  input  logic [LW-1:0]    cfg_quota_i,
  input  logic [SW-1:0]    qry_slot_i,
  output logic [BW-1:0]    qry_bytes_o,
  output logic             deq_valid_o,
  input  logic             deq_ready_i,
  output logic [QID_W-1:0] deq_qid_o,
  output logic [LW-1:0]    deq_len_o
);
  logic [QID_W-1:0]        map_qid;
  logic [SW-1:0]           slot;
  logic [BW-1:0]           thresh_q [NQ];
  logic [NQ-1:0][LW-1:0]   quota_q;
  logic [BW-1:0]           bytes_q  [NQ];
  logic [NQ-1:0]           empty, full;
  logic [EW-1:0]           head     [NQ];
  logic [NQ-1:0][LW-1:0]   head_len;
  logic [BW:0]             want;
  logic                    fits, accept, pop;
  logic [SW-1:0]           sel;

  qcw_qid_map u_map (
    .kind_i (enq_kind_i),
    .qid_i  (enq_qid_i),
    .port_i (enq_port_i),
    .hash_i (enq_hash_i),
    .qid_o  (map_qid)
  );

  assign slot   = map_qid[SW-1:0];
  assign want   = {1'b0, bytes_q[slot]} + (BW+1)'(enq_len_i);
  assign fits   = (want <= {1'b0, thresh_q[slot]}) && !full[slot];
  assign accept = enq_valid_i && fits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_o <= 1'b0;
    else         drop_o <= enq_valid_i && !fits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NQ; i++) begin
        thresh_q[i] <= '1;
        quota_q[i]  <= LW'(QUOTA_RST);
      end
    end else if (cfg_we_i) begin
      thresh_q[cfg_slot_i] <= cfg_thresh_i;
      quota_q[cfg_slot_i]  <= cfg_quota_i;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_slot
    logic push_g, pop_g;
    assign push_g      = accept && (slot == SW'(g));
    assign pop_g       = pop && (sel == SW'(g));
    assign head_len[g] = head[g][LW-1:0];

    qcw_desc_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_g),
      .pop_i   (pop_g),
      .din_i   ({map_qid, enq_len_i}),
      .head_o  (head[g]),
      .empty_o (empty[g]),
      .full_o  (full[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bytes_q[g] <= '0;
      else bytes_q[g] <= bytes_q[g]
                         + (push_g ? BW'(enq_len_i)   : '0)
                         - (pop_g  ? BW'(head_len[g]) : '0);
    end
  end

  qcw_wdrr #(.NQ(NQ), .LW(LW)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .empty_i    (empty),
    .head_len_i (head_len),
    .quota_i    (quota_q),
    .ready_i    (deq_ready_i),
    .valid_o    (deq_valid_o),
    .pop_o      (pop),
    .sel_o      (sel)
  );

  assign deq_qid_o   = head[sel][EW-1:LW];
  assign deq_len_o   = head_len[sel];
  assign qry_bytes_o = bytes_q[qry_slot_i];

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o && !deq_ready_i |=> deq_valid_o && $stable(deq_qid_o) && $stable(deq_len_o));
  // R5
  drop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $past(enq_valid_i));
  // R7
  room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o |-> bytes_q[sel] >= BW'(deq_len_o));
endmodule

// File: tb/sim_qcw_top.sv
module sim_qcw_top;
  localparam int NQ = 8, DEPTH = 4, LW = 12, SW = 3, BW = LW + 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enq_valid = 0, cfg_we = 0, deq_ready = 0;
  logic [1:0] enq_kind = 0;
  logic [8:0] enq_qid = 0;
  logic [2:0] enq_port = 0;
  logic [5:0] enq_hash = 0;
  logic [LW-1:0] enq_len = 0, cfg_quota = 0;
  logic [SW-1:0] cfg_slot = 0, qry_slot = 0;
  logic [BW-1:0] cfg_thresh = 0;
  logic drop, deq_valid;
  logic [BW-1:0] qry_bytes;
  logic [8:0] deq_qid;
  logic [LW-1:0] deq_len;

  always #10 clk = ~clk;

  qcw_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .enq_valid_i(enq_valid), .enq_kind_i(enq_kind),
    .enq_qid_i(enq_qid), .enq_port_i(enq_port), .enq_hash_i(enq_hash), .enq_len_i(enq_len),
    .drop_o(drop), .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_thresh_i(cfg_thresh),
    .cfg_quota_i(cfg_quota), .qry_slot_i(qry_slot), .qry_bytes_o(qry_bytes),
    .deq_valid_o(deq_valid), .deq_ready_i(deq_ready), .deq_qid_o(deq_qid), .deq_len_o(deq_len)
  );

  typedef struct { int qid; int len; string tag; } item_t;
  item_t exp_q[$];
  item_t mq[NQ][$];
  int bq[NQ], bt[NQ];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int map_qid(int kind, int qid, int port, int hash);
    case (kind)
      0: return 440 + hash;
      1: return qid;
      2: return 504 + port;
      default: return 128 + (qid % 128);
    endcase
  endfunction

  function automatic int slot_bytes(int s);
    int b = 0;
    foreach (mq[s][k]) b += mq[s][k].len;
    return b;
  endfunction

  task automatic check_bytes(int s, string tag);
    qry_slot = SW'(s);
    #1;
    chk(int'(qry_bytes) == slot_bytes(s), tag, $sformatf("bytes slot %0d", s), int'(qry_bytes), slot_bytes(s));
  endtask

  task automatic cfg(int s, int th, int qu);
    @(negedge clk);
    cfg_we = 1; cfg_slot = SW'(s); cfg_thresh = BW'(th); cfg_quota = LW'(qu);
    bt[s] = th; bq[s] = qu;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic enq(int kind, int qid, int port, int hash, int len, string tag);
    int q = map_qid(kind, qid, port, hash);
    int s = q % NQ;
    bit dr = (slot_bytes(s) + len > bt[s]) || (mq[s].size() == DEPTH);
    item_t it;
    @(negedge clk);
    enq_valid = 1; enq_kind = 2'(kind); enq_qid = 9'(qid); enq_port = 3'(port);
    enq_hash = 6'(hash); enq_len = LW'(len);
    @(negedge clk);
    enq_valid = 0;
    #5;
    chk(drop == dr, tag, "drop pulse", int'(drop), int'(dr));
    if (!dr) begin
      it.qid = q; it.len = len; it.tag = tag;
      mq[s].push_back(it);
    end
    check_bytes(s, "R4");
  endtask

  // DRR model from the requirements, starting at slot 0 with zero deficits (R10)
  task automatic drain();
    int def[NQ];
    int cur = 0;
    int guard = 0;
    bit busy = 1;
    foreach (def[i]) def[i] = 0;
    while (busy && guard < 10000) begin
      guard++;
      if (mq[cur].size() == 0) def[cur] = 0;
      else begin
        def[cur] += bq[cur];
        while (mq[cur].size() > 0 && mq[cur][0].len <= def[cur]) begin
          def[cur] -= mq[cur][0].len;
          exp_q.push_back(mq[cur].pop_front());
        end
        if (mq[cur].size() == 0) def[cur] = 0;
      end
      cur = (cur + 1) % NQ;
      busy = 0;
      for (int i = 0; i < NQ; i++) if (mq[i].size() > 0) busy = 1;
    end
    for (int k = 0; k < 3000 && exp_q.size() > 0; k++) begin
      @(negedge clk);
      deq_ready = (k % 3 != 2);
    end
    @(negedge clk); deq_ready = 1;
    repeat (3) @(negedge clk);
    deq_ready = 0;
    chk(exp_q.size() == 0, "R8", "missing departures", exp_q.size(), 0);
    for (int i = 0; i < NQ; i++) begin
      #1; check_bytes(i, "R7");
    end
  endtask

  // scoreboard monitor
  initial begin
    bit stall = 0;
    int sq = 0, sl = 0;
    item_t e;
    forever begin
      @(negedge clk);
      #5;
      if (rst_ni) begin
        if (stall)
          chk(deq_valid && int'(deq_qid) == sq && int'(deq_len) == sl, "R11",
              "held offer qid", int'(deq_qid), sq);
        if (deq_valid && deq_ready) begin
          if (exp_q.size() == 0) chk(0, "R8", "unexpected departure qid", int'(deq_qid), -1);
          else begin
            e = exp_q.pop_front();
            chk(int'(deq_qid) == e.qid, e.tag, "departure qid", int'(deq_qid), e.qid);
            chk(int'(deq_len) == e.len, e.tag, "departure len", int'(deq_len), e.len);
          end
        end
        stall = deq_valid && !deq_ready;
        sq = int'(deq_qid); sl = int'(deq_len);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin bt[i] = (1 << BW) - 1; bq[i] = 1500; end
    repeat (3) @(negedge clk);
    #5;
    chk(deq_valid == 0 && drop == 0, "R12", "valid/drop in reset", int'(deq_valid) + int'(drop), 0);
    @(negedge clk); rst_ni = 1;
    #5;
    for (int i = 0; i < NQ; i++) begin #1; check_bytes(i, "R12"); end
    chk(deq_valid == 0, "R12", "valid after reset", int'(deq_valid), 0);

    // mapping of all kinds, reduced slot count
    enq(2, 0, 5, 0, 100, "R1");
    enq(0, 0, 0, 43, 60, "R2");
    enq(3, 7, 0, 0, 70, "R3");
    enq(1, 300, 0, 0, 80, "R3");
    drain();

    // threshold discard (R5), deficit carry (R9)
    cfg(1, 300, 150);
    enq(1, 1, 0, 0, 200, "R9");
    enq(1, 9, 0, 0, 101, "R5");
    enq(1, 17, 0, 0, 100, "R9");
    // full FIFO discard (R6), weighted service (R8)
    cfg(2, (1 << BW) - 1, 15);
    enq(1, 2, 0, 0, 10, "R8");
    enq(1, 10, 0, 0, 10, "R8");
    enq(1, 18, 0, 0, 10, "R8");
    enq(1, 26, 0, 0, 10, "R8");
    enq(1, 34, 0, 0, 10, "R6");
    drain();

    // after idle the round restarts at slot 0 (R10)
    enq(1, 6, 0, 0, 50, "R10");
    enq(1, 1, 0, 0, 50, "R10");
    enq(2, 0, 7, 0, 40, "R1");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule